// File: doc/BRIEF.md
# Multi-Source Reset Controller with Start-Up Delay

This block merges four reset origins into a single active-low system reset: a power-on detector, a supply-level comparator, an external active-low reset pin, and a watchdog expiry strobe. After the last active source goes away, the block keeps the system in reset for a fixed number of clock cycles. Only then does it release the reset. A source that asserts again during that delay restarts the count from zero.

The supply comparator has two modes. It can hold the system in reset, or it can raise a sticky interrupt flag instead. It can also be disabled to save power. The external pin forces reset at once, with no clock edge needed. Its release reaches the delay counter through a two-stage synchronizer.

A watchdog expiry becomes an internal reset pulse one cycle long, and the delay starts when that pulse ends. Each source leaves a sticky cause flag. Software clears a flag by writing a one to it. A power-on event wipes every flag except its own.

Top module: `rstctl_top`

## Requirements
- R1: When `por_det` falls, with no other source active, `sys_rst_n` stays low for TOUT_CYC+1 rising clock edges and goes high after edge TOUT_CYC+2. At that point `cause` reads 4'b0001.
- R2: With `pin_en`=1, a low level on `pin_rst_n` drives `sys_rst_n` low at once, with no clock edge needed. It also sets cause bit 1.
- R3: With `pin_en`=0, the level on `pin_rst_n` has no effect on `sys_rst_n` or on cause bit 1.
- R4: After `pin_rst_n` returns high, `sys_rst_n` rises after the (TOUT_CYC+2)-th rising edge.
- R5: Suppose `wdt_expire` is high at rising edge k. Then `sys_rst_n` is low after edge k and rises after edge k+1+TOUT_CYC, and cause bit 2 becomes set.
- R6: With `lvl_en`=1 and `lvl_rst_mode`=1, a high `lvl_low` holds `sys_rst_n` low from the next edge for as long as it stays high, and sets cause bit 3. Once `lvl_low` falls, `sys_rst_n` rises after TOUT_CYC edges.
- R7: With `lvl_en`=1 and `lvl_rst_mode`=0, a high `lvl_low` sets `lvl_irq` at the next edge and leaves `sys_rst_n` high.
- R8: With `lvl_en`=0, `lvl_low` changes neither `lvl_irq`, `sys_rst_n` nor cause bit 3.
- R9: A source that reasserts during the delay restarts the count from zero.
- R10: Cause flag bits are 0 for power-on, 1 for the pin, 2 for the watchdog and 3 for the supply monitor. Writing a one to a bit of `cause_clr` clears only that bit at the next edge.
- R11: While `por_det` is high, `cause` reads zero. A power-on event clears bits 3:1 and sets bit 0.
- R12: `lvl_irq` stays set after `lvl_low` falls, until a cycle with `irq_clr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Delay and flag clock |
| por_det | input | 1 | Power-on detect, high while power is not good |
| lvl_low | input | 1 | Supply comparator output, high when the supply is below the threshold |
| lvl_en | input | 1 | Supply monitor enable |
| lvl_rst_mode | input | 1 | 1: supply low holds reset, 0: supply low raises interrupt |
| pin_rst_n | input | 1 | External reset pin, active low |
| pin_en | input | 1 | Enables the external pin reset |
| wdt_expire | input | 1 | Watchdog expiry strobe |
| cause_clr | input | 4 | Write-one-to-clear for the cause flags |
| irq_clr | input | 1 | Clears the supply interrupt flag |
| sys_rst_n | output | 1 | System reset, active low |
| lvl_irq | output | 1 | Sticky supply-low interrupt flag |
| cause | output | 4 | Sticky reset cause flags |

## Verification
The bench measures the release edge exactly for each source, because each path has its own latency. Power-on and pin releases pass through the synchronizer. Watchdog and supply releases do not. A counter that is off by one, or a synchronizer stage too many or too few, moves `sys_rst_n` by a cycle and is caught. The bench asserts the pin between clock edges and samples before the next edge. A pin path that only acts on a clock would miss it.

A second pin pulse during the count exposes a counter that does not restart. Scenario vectors for the supply monitor cover the interrupt mode, the reset mode and the disabled state. A design that routes the comparator to the wrong action, or ignores the enable, shows up there as a wrong reset, a wrong interrupt, or a wrong cause flag.

// File: rtl/rstctl_pkg.sv
// Shared constants for the reset controller: cause flag bit positions.
package rstctl_pkg;
    localparam int CAUSE_W = 4;
    localparam int CZ_POR  = 0;
    localparam int CZ_PIN  = 1;
    localparam int CZ_WDT  = 2;
    localparam int CZ_LVL  = 3;
endpackage

// File: rtl/rstctl_sync.sv
// Release synchronizer: the output drops at once when arst_n falls.
// It rises only after STAGES clock edges with arst_n high.
// Assumes arst_n is glitch-free.
module rstctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift a one through the chain; clear the whole chain asynchronously
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstctl_delay.sv
// Start-up delay counter. Any hold cycle or async clear restarts it from zero.
// done is high once TOUT cycles have passed without a hold.
module rstctl_delay #(
    parameter int TOUT = 64
) (
    input  logic clk,
    input  logic arst_n,
    input  logic hold,
    output logic done
);
    localparam int CW = $clog2(TOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TOUT);

    logic [CW-1:0] cnt;

    // count up to LAST, restart on hold or async clear
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          cnt <= '0;
        else if (hold)        cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/rstctl_flags.sv
// Sticky reset-cause flags and the supply interrupt flag, all write-one-to-clear.
// A power-on event clears everything and sets the power-on flag.
// The pin flag is set asynchronously so that it is recorded without a clock.
module rstctl_flags
    import rstctl_pkg::*;
(
    input  logic               clk,
    input  logic               por_det,
    input  logic               pin_act,
    input  logic               wdt_evt,
    input  logic               lvl_rst_evt,
    input  logic               lvl_irq_evt,
    input  logic [CAUSE_W-1:0] cause_clr,
    input  logic               irq_clr,
    output logic [CAUSE_W-1:0] cause,
    output logic               lvl_irq
);
    logic por_f, pin_f, wdt_f, lvl_f, irq_f;

    // power-on flag: set by power-on, cleared by software
    always_ff @(posedge clk or posedge por_det) begin
        if (por_det)              por_f <= 1'b1;
        else if (cause_clr[CZ_POR]) por_f <= 1'b0;
    end

    // pin flag: async set by the pin, cleared by power-on or software
    always_ff @(posedge clk or posedge por_det or posedge pin_act) begin
        if (por_det)                pin_f <= 1'b0;
        else if (pin_act)           pin_f <= 1'b1;
        else if (cause_clr[CZ_PIN]) pin_f <= 1'b0;
    end

    // watchdog, supply and interrupt flags: set wins over clear
    always_ff @(posedge clk or posedge por_det) begin
        if (por_det) begin
            wdt_f <= 1'b0;
            lvl_f <= 1'b0;
            irq_f <= 1'b0;
        end else begin
            if (wdt_evt)                wdt_f <= 1'b1;
            else if (cause_clr[CZ_WDT]) wdt_f <= 1'b0;
            if (lvl_rst_evt)            lvl_f <= 1'b1;
            else if (cause_clr[CZ_LVL]) lvl_f <= 1'b0;
            if (lvl_irq_evt)            irq_f <= 1'b1;
            else if (irq_clr)           irq_f <= 1'b0;
        end
    end

    // flags read as zero until power is good
    assign cause   = {lvl_f, wdt_f, pin_f, por_f} & {CAUSE_W{~por_det}};
    assign lvl_irq = irq_f;
endmodule

// File: rtl/rstctl_top.sv
// Reset controller top. Merges the power-on, pin, watchdog and supply-monitor sources.
// The system reset is released after a TOUT_CYC start-up delay.
// Assumes the analog detectors deliver clean digital levels and that
// wdt_expire is a single-cycle strobe.
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int TOUT_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_det,
    input  logic               lvl_low,
    input  logic               lvl_en,
    input  logic               lvl_rst_mode,
    input  logic               pin_rst_n,
    input  logic               pin_en,
    input  logic               wdt_expire,
    input  logic [CAUSE_W-1:0] cause_clr,
    input  logic               irq_clr,
    output logic               sys_rst_n,
    output logic               lvl_irq,
    output logic [CAUSE_W-1:0] cause
);
    logic pin_act, arst_n, pin_ok, wdt_pulse, lvl_hold, lvl_irq_evt, hold;

    assign pin_act     = pin_en & ~pin_rst_n;
    assign arst_n      = ~(por_det | pin_act);
    assign lvl_hold    = lvl_en & lvl_rst_mode & lvl_low;
    assign lvl_irq_evt = lvl_en & ~lvl_rst_mode & lvl_low;

    rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .q      (pin_ok)
    );

    // one-cycle internal watchdog reset pulse
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) wdt_pulse <= 1'b0;
        else         wdt_pulse <= wdt_expire;
    end

    assign hold = ~pin_ok | wdt_expire | wdt_pulse | lvl_hold;

    rstctl_delay #(.TOUT(TOUT_CYC)) u_delay (
        .clk    (clk),
        .arst_n (arst_n),
        .hold   (hold),
        .done   (sys_rst_n)
    );

    rstctl_flags u_flags (
        .clk         (clk),
        .por_det     (por_det),
        .pin_act     (pin_act),
        .wdt_evt     (wdt_pulse),
        .lvl_rst_evt (lvl_hold),
        .lvl_irq_evt (lvl_irq_evt),
        .cause_clr   (cause_clr),
        .irq_clr     (irq_clr),
        .cause       (cause),
        .lvl_irq     (lvl_irq)
    );
endmodule

// File: rtl/rstctl_chk.sv
// Property checker for rstctl_top, attached through bind. Inactive during power-on.
module rstctl_chk (
    input logic       clk,
    input logic       por_det,
    input logic       lvl_low,
    input logic       lvl_en,
    input logic       lvl_rst_mode,
    input logic       pin_rst_n,
    input logic       pin_en,
    input logic       wdt_expire,
    input logic [3:0] cause_clr,
    input logic       irq_clr,
    input logic       sys_rst_n,
    input logic       lvl_irq,
    input logic [3:0] cause
);
    // R2
    pin_forces_reset_chk: assert property (@(posedge clk) disable iff (por_det)
        (pin_en && !pin_rst_n) |-> !sys_rst_n);
    // R5
    wdt_resets_chk: assert property (@(posedge clk) disable iff (por_det)
        wdt_expire |=> !sys_rst_n);
    // R6
    lvl_holds_reset_chk: assert property (@(posedge clk) disable iff (por_det)
        (lvl_en && lvl_rst_mode && lvl_low) |=> !sys_rst_n);
    // R7
    lvl_sets_irq_chk: assert property (@(posedge clk) disable iff (por_det)
        (lvl_en && !lvl_rst_mode && lvl_low) |=> lvl_irq);
    // R12
    irq_sticky_chk: assert property (@(posedge clk) disable iff (por_det)
        (lvl_irq && !irq_clr) |=> lvl_irq);
    // R10
    wdt_flag_sticky_chk: assert property (@(posedge clk) disable iff (por_det)
        (cause[2] && !cause_clr[2]) |=> cause[2]);
endmodule

bind rstctl_top rstctl_chk u_chk (
    .clk          (clk),
    .por_det      (por_det),
    .lvl_low      (lvl_low),
    .lvl_en       (lvl_en),
    .lvl_rst_mode (lvl_rst_mode),
    .pin_rst_n    (pin_rst_n),
    .pin_en       (pin_en),
    .wdt_expire   (wdt_expire),
    .cause_clr    (cause_clr),
    .irq_clr      (irq_clr),
    .sys_rst_n    (sys_rst_n),
    .lvl_irq      (lvl_irq),
    .cause        (cause)
);

// File: tb/rstctl_top_bench.sv
// Self-checking bench for rstctl_top: a supply-monitor vector table, then directed tests.
module rstctl_top_bench;
    localparam int TOUT = 64;

    logic       clk = 1'b0;
    logic       por_det = 1'b1, lvl_low = 1'b0, lvl_en = 1'b0, lvl_rst_mode = 1'b0;
    logic       pin_rst_n = 1'b1, pin_en = 1'b1, wdt_expire = 1'b0, irq_clr = 1'b0;
    logic [3:0] cause_clr = 4'b0;
    logic       sys_rst_n, lvl_irq;
    logic [3:0] cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Vector fields: {lvl_en, lvl_rst_mode, lvl_low, expect_irq, expect_reset}
    localparam logic [4:0] VEC [5] = '{
        5'b01100,  // R8: disabled, reset mode
        5'b00100,  // R8: disabled, interrupt mode
        5'b10110,  // R7: interrupt mode
        5'b11101,  // R6: reset mode
        5'b11000   // supply fine
    };

    rstctl_top #(.TOUT_CYC(TOUT)) u_rstctl_top (
        .clk(clk), .por_det(por_det), .lvl_low(lvl_low), .lvl_en(lvl_en),
        .lvl_rst_mode(lvl_rst_mode), .pin_rst_n(pin_rst_n), .pin_en(pin_en),
        .wdt_expire(wdt_expire), .cause_clr(cause_clr), .irq_clr(irq_clr),
        .sys_rst_n(sys_rst_n), .lvl_irq(lvl_irq), .cause(cause)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_check(input int edges_low, input string req);
        clks(edges_low);
        chk(sys_rst_n == 1'b0, req, sys_rst_n, 0);
        clks(1);
        chk(sys_rst_n == 1'b1, req, sys_rst_n, 1);
    endtask

    initial begin
        clks(3);
        // R11: flags hidden during power-on
        chk(cause == 4'b0000, "R11", cause, 0);
        chk(sys_rst_n == 1'b0, "R1", sys_rst_n, 0);
        por_det = 1'b0;
        release_check(TOUT + 1, "R1");
        chk(cause == 4'b0001, "R1", cause, 1);
        cause_clr = 4'b0001; clks(1); cause_clr = 4'b0;
        chk(cause == 4'b0000, "R10", cause, 0);

        // supply-monitor table
        for (int i = 0; i < 5; i++) begin
            {lvl_en, lvl_rst_mode, lvl_low} = VEC[i][4:2];
            clks(1);
            chk(lvl_irq == VEC[i][1], "R7", lvl_irq, VEC[i][1]);
            chk(sys_rst_n == !VEC[i][0], "R6", sys_rst_n, !VEC[i][0]);
            chk(cause[3] == VEC[i][0], "R8", cause[3], VEC[i][0]);
            lvl_low = 1'b0;
            clks(1);
            chk(lvl_irq == VEC[i][1], "R12", lvl_irq, VEC[i][1]);
            irq_clr = 1'b1; cause_clr = 4'b1000;
            clks(1);
            irq_clr = 1'b0; cause_clr = 4'b0;
            chk(lvl_irq == 1'b0, "R12", lvl_irq, 0);
            chk(cause[3] == 1'b0, "R10", cause[3], 0);
            clks(TOUT + 2);
            chk(sys_rst_n == 1'b1, "R6", sys_rst_n, 1);
        end

        // R6: long hold, then release after TOUT edges
        lvl_en = 1'b1; lvl_rst_mode = 1'b1; lvl_low = 1'b1;
        clks(20);
        chk(sys_rst_n == 1'b0, "R6", sys_rst_n, 0);
        lvl_low = 1'b0;
        release_check(TOUT - 1, "R6");
        lvl_en = 1'b0;
        cause_clr = 4'b1111; clks(1); cause_clr = 4'b0;

        // R2: pin asserted between edges acts before any clock edge
        #3 pin_rst_n = 1'b0;
        #1 chk(sys_rst_n == 1'b0, "R2", sys_rst_n, 0);
        chk(cause[1] == 1'b1, "R2", cause[1], 1);
        @(negedge clk);
        pin_rst_n = 1'b1;
        release_check(TOUT + 1, "R4");

        // R9: pin pulse again during the delay restarts the count
        pin_rst_n = 1'b0; clks(1); pin_rst_n = 1'b1;
        clks(10);
        #3 pin_rst_n = 1'b0;
        @(negedge clk);
        pin_rst_n = 1'b1;
        release_check(TOUT + 1, "R9");

        // R10: clearing bit 2 leaves bit 1 set
        cause_clr = 4'b0100; clks(1); cause_clr = 4'b0;
        chk(cause == 4'b0010, "R10", cause, 2);

        // R3: pin ignored while disabled
        cause_clr = 4'b0010; clks(1); cause_clr = 4'b0;
        pin_en = 1'b0; pin_rst_n = 1'b0;
        clks(5);
        chk(sys_rst_n == 1'b1, "R3", sys_rst_n, 1);
        chk(cause[1] == 1'b0, "R3", cause[1], 0);
        pin_rst_n = 1'b1; pin_en = 1'b1;

        // R5: watchdog strobe
        wdt_expire = 1'b1; clks(1); wdt_expire = 1'b0;
        chk(sys_rst_n == 1'b0, "R5", sys_rst_n, 0);
        release_check(TOUT, "R5");
        chk(cause == 4'b0100, "R5", cause, 4);

        // R11: power-on wipes other flags
        lvl_en = 1'b1; lvl_rst_mode = 1'b1; lvl_low = 1'b1; clks(1);
        lvl_low = 1'b0; lvl_en = 1'b0;
        chk(cause == 4'b1100, "R10", cause, 12);
        por_det = 1'b1; clks(2);
        chk(cause == 4'b0000, "R11", cause, 0);
        por_det = 1'b0; clks(1);
        chk(cause == 4'b0001, "R11", cause, 1);
        clks(TOUT + 2);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog timeout actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule